// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Protection Unit

This block keeps the status byte of a serial EEPROM and rules on every write that the command decoder presents. It holds a busy flag, a write-enable latch, a two-bit protection selector and a status-write lock bit. From these, the target address and the hardware write-protect pin, it decides in one clock whether a memory write or a status write is granted or refused. A granted write starts a fixed-length busy timer. The memory array, or any other source, can also end the busy period early with a done pulse.

The serial shifter around the block decodes instructions into one-cycle strobes and drives the write address and the status data. It reads `status_o` at any time. The protection selector covers no memory, the top quarter, the top half or the whole array. Once the lock bit is set, pulling the write-protect pin low freezes the selector and the lock bit.

The lock bit and the selector model non-volatile cells. Reset does not touch them, and only a granted status write changes them. Reset clears the busy flag and the write-enable latch.

Top module: `eeprom_status_guard`

## Requirements
- R1: While `rst_ni` is low, the busy flag and the write-enable latch clear to 0. The lock bit and the protection selector keep the values they held before reset.
- R2: The fields of `status_o` sit at fixed bits: lock bit at 7, selector high bit at 3, selector low bit at 2, write-enable latch at 1, busy at 0. Bits 6:4 always read 0. A status write loads bits 7, 3 and 2 of `wr_data_i` and ignores its other bits.
- R3: A write-enable strobe sets the write-enable latch. A write-disable strobe clears it.
- R4: A status-write strobe is granted only when the write-enable latch is 1 and it is not the case that the lock bit is 1 while `wp_ni` is 0. A grant updates the lock bit and the selector at that clock edge, pulses `sr_grant_o` for the next cycle and starts the busy period.
- R5: The selector encodes protection as follows: 00 protects nothing, 01 protects addresses at or above 3/4 of the address space, 10 protects addresses at or above 1/2, and 11 protects every address. A memory-write strobe is granted, pulsing `mem_grant_o` for the next cycle and starting the busy period, only when the write-enable latch is 1 and the address is not protected.
- R6: A refused memory write or status write pulses `deny_o` for the next cycle and clears the write-enable latch. The lock bit and the selector stay unchanged.
- R7: After a grant, the busy flag stays 1 for exactly `WRITE_CYCLES` cycles, then clears together with the write-enable latch. A `cycle_done_i` pulse while busy ends the busy period at the next edge.
- R8: While the busy flag is 1, every command strobe is ignored: there is no grant, no deny and no change to the latch. `status_o` keeps showing the live busy flag.
- R9: `standby_o` is 1 exactly when `cs_ni` is high and the busy flag is 0. A deselected device stays active until its write completes.
- R10: When `abort_i` is high, every command strobe in that cycle is ignored. The abort by itself leaves the write-enable latch and the busy flag unchanged.
- R11: At most one command strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| sr_write_i | input | 1 | Status-write strobe |
| mem_write_i | input | 1 | Memory-write strobe |
| abort_i | input | 1 | Transaction aborted (deselected while paused) |
| addr_i | input | ADDR_W | Target address of the memory write |
| wr_data_i | input | 8 | Data byte of the status write |
| wp_ni | input | 1 | Write-protect pin, active low |
| cs_ni | input | 1 | Chip select, active low |
| cycle_done_i | input | 1 | Early end of the internal write cycle |
| status_o | output | 8 | Live status byte |
| mem_grant_o | output | 1 | Memory write granted (one-cycle pulse) |
| sr_grant_o | output | 1 | Status write granted (one-cycle pulse) |
| deny_o | output | 1 | Write refused (one-cycle pulse) |
| standby_o | output | 1 | Device may enter standby |

## Verification
Two events can land on the same clock edge: a command strobe and the end of the busy period, or a command strobe and an abort. The bench raises the early-done input while the latch is still set and checks that the latch and the busy flag clear together. It sends a write-enable strobe together with an abort and checks that the latch stays at 0. It also fires write-disable and memory-write strobes in the middle of a busy period and checks that the latch, the grant output and the deny output do not move. Sweeps over the four selector codes at the region-boundary addresses, and over the lock, pin and latch combinations, compare each grant or refusal with a protection model computed in the bench.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_sel_e;

  typedef struct packed {
    logic      lock;
    prot_sel_e sel;
  } nv_bits_t;

  localparam int unsigned LOCK_BIT = 7;
  localparam int unsigned SEL1_BIT = 3;
  localparam int unsigned SEL0_BIT = 2;
  localparam int unsigned WEL_BIT  = 1;
  localparam int unsigned BUSY_BIT = 0;
endpackage

// File: rtl/sr_prot_decode.sv
module sr_prot_decode
  import sr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  prot_sel_e         sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned TOP = ADDR_W - 1;

  logic upper_half, upper_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign upper_half    = addr_i[TOP];
      assign upper_quarter = addr_i[TOP] & addr_i[TOP-1];
    end else begin : g_narrow
      assign upper_half    = addr_i[TOP];
      assign upper_quarter = addr_i[TOP];
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      PROT_NONE:    hit_o = 1'b0;
      PROT_QUARTER: hit_o = upper_quarter;
      PROT_HALF:    hit_o = upper_half;
      default:      hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_busy_timer.sv
module sr_busy_timer #(
  parameter int unsigned WRITE_CYCLES = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ext_done_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WRITE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q & ((cnt_q == '0) | ext_done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end
  end
endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard
  import sr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W       = 17,
  parameter int unsigned WRITE_CYCLES = 500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              sr_write_i,
  input  logic              mem_write_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              wp_ni,
  input  logic              cs_ni,
  input  logic              cycle_done_i,
  output logic [7:0]        status_o,
  output logic              mem_grant_o,
  output logic              sr_grant_o,
  output logic              deny_o,
  output logic              standby_o
);
  nv_bits_t nv_q;
  logic     wel_q, busy, done;
  logic     mem_grant_q, sr_grant_q, deny_q;
  logic     prot_hit, accept;
  logic     wren_v, wrdi_v, srw_v, memw_v;
  logic     sr_ok, mem_ok, srw_go, memw_go, refuse;

  // strobes are dropped while busy or on an aborted transaction
  assign accept  = ~busy & ~abort_i;
  assign wren_v  = wren_i & accept;
  assign wrdi_v  = wrdi_i & accept;
  assign srw_v   = sr_write_i & accept;
  assign memw_v  = mem_write_i & accept;

  assign sr_ok   = wel_q & ~(nv_q.lock & ~wp_ni);
  assign mem_ok  = wel_q & ~prot_hit;
  assign srw_go  = srw_v & sr_ok;
  assign memw_go = memw_v & mem_ok;
  assign refuse  = (srw_v & ~sr_ok) | (memw_v & ~mem_ok);

  sr_prot_decode #(.ADDR_W(ADDR_W)) u_prot (
    .sel_i  (nv_q.sel),
    .addr_i (addr_i),
    .hit_o  (prot_hit)
  );

  sr_busy_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (srw_go | memw_go),
    .ext_done_i (cycle_done_i),
    .busy_o     (busy),
    .done_o     (done)
  );

  // non-volatile cells: untouched by reset
  always_ff @(posedge clk_i) begin
    if (srw_go) begin
      nv_q.lock <= wr_data_i[LOCK_BIT];
      nv_q.sel  <= prot_sel_e'({wr_data_i[SEL1_BIT], wr_data_i[SEL0_BIT]});
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q       <= 1'b0;
      mem_grant_q <= 1'b0;
      sr_grant_q  <= 1'b0;
      deny_q      <= 1'b0;
    end else begin
      mem_grant_q <= memw_go;
      sr_grant_q  <= srw_go;
      deny_q      <= refuse;
      if (done || refuse)  wel_q <= 1'b0;
      else if (wren_v)     wel_q <= 1'b1;
      else if (wrdi_v)     wel_q <= 1'b0;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[LOCK_BIT] = nv_q.lock;
    status_o[SEL1_BIT] = nv_q.sel[1];
    status_o[SEL0_BIT] = nv_q.sel[0];
    status_o[WEL_BIT]  = wel_q;
    status_o[BUSY_BIT] = busy;
  end

  assign mem_grant_o = mem_grant_q;
  assign sr_grant_o  = sr_grant_q;
  assign deny_o      = deny_q;
  assign standby_o   = cs_ni & ~busy;
endmodule

// File: rtl/eeprom_status_guard_chk.sv
module eeprom_status_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wren_i,
  input logic       wrdi_i,
  input logic       sr_write_i,
  input logic       mem_write_i,
  input logic       abort_i,
  input logic       wp_ni,
  input logic       cs_ni,
  input logic [7:0] status_o,
  input logic       mem_grant_o,
  input logic       sr_grant_o,
  input logic       deny_o,
  input logic       standby_o
);
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wren_i, wrdi_i, sr_write_i, mem_write_i})); // R11

  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6:4] == 3'b000); // R2

  AST_OUTCOME_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_grant_o, sr_grant_o, deny_o})); // R6

  AST_GRANT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_grant_o || sr_grant_o) |-> status_o[0]); // R7

  AST_DENY_CLEARS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o |-> !status_o[1]); // R6

  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[7] && !wp_ni) |=> $stable(status_o[7:2])); // R4

  AST_BUSY_IGNORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && (sr_write_i || mem_write_i)) |=> !(mem_grant_o || sr_grant_o || deny_o)); // R8

  AST_ABORT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !status_o[0]) |=> $stable(status_o[1:0])); // R10

  AST_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o == (cs_ni && !status_o[0])); // R9
endmodule

bind eeprom_status_guard eeprom_status_guard_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wren_i      (wren_i),
  .wrdi_i      (wrdi_i),
  .sr_write_i  (sr_write_i),
  .mem_write_i (mem_write_i),
  .abort_i     (abort_i),
  .wp_ni       (wp_ni),
  .cs_ni       (cs_ni),
  .status_o    (status_o),
  .mem_grant_o (mem_grant_o),
  .sr_grant_o  (sr_grant_o),
  .deny_o      (deny_o),
  .standby_o   (standby_o)
);

// File: tb/eeprom_status_guard_test.sv
module eeprom_status_guard_test;
  localparam int unsigned AW = 17;
  localparam int unsigned WC = 6;
  localparam int unsigned Q  = 1 << (AW - 2);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wren = 0, wrdi = 0, srw = 0, memw = 0, abort = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic wp_n = 1'b1, cs_n = 1'b0, cdone = 1'b0;
  logic [7:0] status;
  logic g_mem, g_sr, deny, stby;

  int checks = 0, fails = 0;
  logic c_mem, c_sr, c_den;
  bit done_flag = 0;

  always #5 clk = ~clk;

  eeprom_status_guard #(.ADDR_W(AW), .WRITE_CYCLES(WC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wren_i(wren), .wrdi_i(wrdi),
    .sr_write_i(srw), .mem_write_i(memw), .abort_i(abort),
    .addr_i(addr), .wr_data_i(data), .wp_ni(wp_n), .cs_ni(cs_n),
    .cycle_done_i(cdone), .status_o(status), .mem_grant_o(g_mem),
    .sr_grant_o(g_sr), .deny_o(deny), .standby_o(stby)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // 0 wren, 1 wrdi, 2 status write, 3 memory write
  task automatic strobe(input int which, input logic [7:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    data = d; addr = a;
    wren = (which == 0); wrdi = (which == 1);
    srw = (which == 2); memw = (which == 3);
    @(negedge clk);
    wren = 0; wrdi = 0; srw = 0; memw = 0;
    c_mem = g_mem; c_sr = g_sr; c_den = deny;
  endtask

  task automatic wait_idle();
    while (status[0]) @(negedge clk);
  endtask

  task automatic set_status(input logic [7:0] d);
    strobe(0, 8'h00, '0);
    strobe(2, d, '0);
    wait_idle();
  endtask

  function automatic bit prot(input int bp, input int a);
    case (bp)
      0: return 1'b0;
      1: return a >= 3 * Q;
      2: return a >= 2 * Q;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int probe(input int i);
    case (i)
      0: return 0;
      1: return Q;
      2: return 2 * Q - 1;
      3: return 2 * Q;
      4: return 3 * Q - 1;
      5: return 3 * Q;
      6: return 3 * Q + 5;
      default: return 4 * Q - 1;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: volatile bits clear
    chk(status[1:0] == 2'b00, "R1 reset wel/wip", int'(status[1:0]), 0);
    chk(status[6:4] == 3'b000, "R2 unused bits", int'(status[6:4]), 0);
    rst_n = 1'b1;
    set_status(8'h00);
    chk(status == 8'h00, "R2 cleared status", status, 0);

    // R3
    strobe(0, 0, '0);
    chk(status == 8'h02, "R3 wren sets wel", status, 8'h02);
    strobe(1, 0, '0);
    chk(status == 8'h00, "R3 wrdi clears wel", status, 8'h00);

    // R2: only bits 7,3,2 of data are loaded
    set_status(8'h7F);
    chk(status == 8'h0C, "R2 field load", status, 8'h0C);

    // R1: non-volatile bits survive reset, wel cleared
    set_status(8'h88);
    strobe(0, 0, '0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'h88, "R1 nv kept across reset", status, 8'h88);
    set_status(8'h00);

    // R4/R6: lock, pin and latch sweep
    for (int lk = 0; lk < 2; lk++)
      for (int wp = 0; wp < 2; wp++)
        for (int we = 0; we < 2; we++) begin
          automatic logic [7:0] base = {lk[0], 3'b000, 2'b01, 2'b00};
          automatic bit ok = (we == 1) && !(lk == 1 && wp == 0);
          wp_n = 1'b1;
          set_status(base);
          wp_n = wp[0];
          if (we == 1) strobe(0, 0, '0);
          strobe(2, 8'h08, '0);
          chk(c_sr == ok, "R4 status write grant", c_sr, ok);
          chk(c_den == !ok, "R6 status write deny", c_den, !ok);
          wait_idle();
          chk(status == (ok ? 8'h08 : base), "R4 status after write", status, ok ? 8'h08 : base);
        end
    wp_n = 1'b1;

    // R6: write without latch is refused
    set_status(8'h00);
    strobe(3, 0, '0);
    chk(c_den == 1'b1 && c_mem == 1'b0, "R6 mem write without wel", c_den, 1);

    // R5: protection sweep
    for (int bp = 0; bp < 4; bp++) begin
      set_status(8'(bp << 2));
      for (int i = 0; i < 8; i++) begin
        automatic int a = probe(i);
        automatic bit ok = !prot(bp, a);
        strobe(0, 0, '0);
        strobe(3, 0, AW'(a));
        chk(c_mem == ok, "R5 mem grant", c_mem, ok);
        chk(c_den == !ok, "R6 mem deny", c_den, !ok);
        wait_idle();
        chk(status[1:0] == 2'b00, "R6 wel cleared after outcome", status[1:0], 0);
        chk(status[3:2] == 2'(bp), "R6 selector unchanged", status[3:2], bp);
      end
    end

    // R7: busy length
    set_status(8'h00);
    strobe(0, 0, '0);
    strobe(3, 0, '0);
    begin
      int n = 0;
      while (status[0] && n < 100) begin n++; @(negedge clk); end
      chk(n == WC, "R7 busy length", n, WC);
    end
    chk(status[1] == 1'b0, "R7 wel cleared at completion", status[1], 0);

    // R8: strobes ignored while busy
    strobe(0, 0, '0);
    strobe(3, 0, '0);
    strobe(1, 0, '0);
    chk(status[1] == 1'b1 && c_den == 0, "R8 wrdi ignored while busy", status[1], 1);
    strobe(3, 0, '0);
    chk(c_mem == 0 && c_den == 0, "R8 write ignored while busy", {c_mem, c_den}, 0);
    chk(status[0] == 1'b1, "R8 live busy bit", status[0], 1);
    wait_idle();

    // R7: early completion coincides with latch clear
    strobe(0, 0, '0);
    strobe(3, 0, '0);
    cdone = 1'b1;
    @(negedge clk);
    cdone = 1'b0;
    chk(status[1:0] == 2'b00, "R7 early done", status[1:0], 0);

    // R10: abort drops strobes and keeps state
    @(negedge clk); abort = 1'b1; wren = 1'b1;
    @(negedge clk); abort = 1'b0; wren = 1'b0;
    chk(status[1] == 1'b0, "R10 wren dropped on abort", status[1], 0);
    strobe(0, 0, '0);
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk(status[1:0] == 2'b10, "R10 abort keeps wel", status[1:0], 2);

    // R9: standby only when idle and deselected
    cs_n = 1'b1;
    strobe(3, 0, '0);
    chk(stby == 1'b0, "R9 active while busy", stby, 0);
    wait_idle();
    chk(stby == 1'b1, "R9 standby when idle", stby, 1);
    cs_n = 1'b0;
    #1;
    chk(stby == 1'b0, "R9 selected is active", stby, 0);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule